// File: doc/BRIEF.md
# Tape Command Acceptance and Reject Sequencer

This block is the control sequencer at the host side of a four-unit magnetic tape controller. A control strobe latches a 16-bit control word. The sequencer then decodes the unit and operation fields and checks the operation against the addressed drive's status and against the channel's two transfer flags. The outcome is one of these: a unit select, an immediate tape motion start, a data command that waits for the channel to begin the transfer, a no-motion acceptance, or a reject. A reject raises an interrupt after a programmable tape stop delay.

Whenever an interrupt is pending or active, the sequencer stays in a hold state and evaluates no command. A strobe that arrives during the hold is still latched and runs once the hold ends. While no channel program is active and nothing is pending, the sequencer walks the units in round-robin order. It raises an interrupt when a unit that was not ready becomes ready. The actual tape motion and data movement are outside the block. An execution handshake (a start pulse out, and done and error in) stands for them.

Word bits are numbered 0 (most significant) to 15 (least significant). In port terms the unit field is `ctl_word[9:8]`, the reserved field is `ctl_word[7:4]` and the operation code is `ctl_word[3:0]`.

Top module: `tape_cmd_seq`

## Requirements
- R1: A latched word whose reserved field `ctl_word[7:4]` is nonzero, or whose operation code is 1, 2 or 3, is rejected. Every evaluated word copies its unit field `ctl_word[9:8]` into `sel_unit`.
- R2: Operation code 0 (select) is accepted whatever the state of the unit's ready input. It loads `sel_unit` and sets `svc_req`, and it starts no motion.
- R3: Any other operation addressed to a unit whose `unit_rdy` bit is low is rejected. A write-class operation (codes 8 to 11) addressed to a unit whose `unit_wring` bit is low is also rejected.
- R4: A read-data operation (codes 4, 5) or a write-data operation (codes 8, 9) sets `svc_req` and waits. When the matching transfer flag is set (`in_xfer` for read, `out_xfer` for write), `exec_start` pulses. The opposite flag, or a new strobe, while the operation waits is rejected.
- R5: Either transfer flag set while the sequencer expects a control word is rejected.
- R6: Backspace record (12) or backspace file (13) addressed to a unit whose `unit_lp` bit is high is accepted with `svc_req` and starts no motion.
- R7: Any other accepted operation (codes 6, 7, 10, 11, 12 and 13 off load point, 14 and 15) pulses `exec_start` with the code on `exec_cmd`. On `exec_done`, `exec_err` low sets `svc_req`, and `exec_err` high requests an interrupt. Both outcomes clear the transfer flags.
- R8: A reject sets `rej_flag` on the cycle after evaluation. `int_req` rises exactly STOP_CYC cycles after `rej_flag` is set.
- R9: Raising `int_req` clears both transfer flags and `svc_req`. No command is evaluated while `int_req` or `int_act` is set. A strobe received in this hold state runs once both flags are clear.
- R10: When idle with `sio_active` low and no word pending, each cycle advances `sel_unit` by one, modulo 4. The sequencer requests an interrupt when the unit just selected reads ready but was not ready the last time it was polled.
- R11: `int_ack` while `int_req` is set clears `int_req` and sets `int_act`. `int_clr` clears `int_act`.
- R12: `mclr` or `rst_n` returns every flag to zero, selects unit 0 and forgets the polled ready history. `bus_clr` clears both transfer flags and `svc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mclr | input | 1 | Synchronous master reset |
| bus_clr | input | 1 | Clears transfer flags and service request |
| ctl_stb | input | 1 | Control word strobe |
| ctl_word | input | 16 | Control word |
| in_xfer_tgl | input | 1 | Channel begins an inbound (read) transfer |
| out_xfer_tgl | input | 1 | Channel begins an outbound (write) transfer |
| sio_active | input | 1 | A channel program is running; suppresses polling |
| unit_rdy | input | 4 | Per-unit ready |
| unit_wring | input | 4 | Per-unit write ring present |
| unit_lp | input | 4 | Per-unit at load point |
| exec_done | input | 1 | Motion or transfer finished |
| exec_err | input | 1 | With exec_done: error exit or runaway |
| int_ack | input | 1 | Host acknowledges the interrupt request |
| int_clr | input | 1 | Host ends interrupt service |
| sel_unit | output | 2 | Currently selected unit |
| svc_req | output | 1 | Service request to the channel |
| rej_flag | output | 1 | Last evaluation was rejected |
| int_req | output | 1 | Interrupt request |
| int_act | output | 1 | Interrupt active |
| in_xfer | output | 1 | Inbound transfer flag |
| out_xfer | output | 1 | Outbound transfer flag |
| exec_start | output | 1 | One-cycle start pulse to the motion engine |
| exec_cmd | output | 4 | Operation code being executed |
| busy | output | 1 | Sequencer not in its idle loop |

## Verification
All outputs are registered. A word strobed at one clock edge is evaluated at the next edge, so its select, accept, start or reject result appears on the ports one cycle after the strobe becomes visible. A transfer toggle likewise leads to `exec_start` one edge after the flag shows. A reject then holds off `int_req` for exactly STOP_CYC further cycles. The bench model advances on the same edges and applies the same order of overriding updates, and every port is compared on the falling edge of every cycle, so each of these latencies is checked to the exact cycle.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EXEC,
    ST_REJ,
    ST_HOLD
  } seq_state_t;

  localparam logic [3:0] OP_SEL = 4'd0;
  localparam logic [3:0] OP_RD  = 4'd4;
  localparam logic [3:0] OP_RDC = 4'd5;
  localparam logic [3:0] OP_WR  = 4'd8;
  localparam logic [3:0] OP_WRZ = 4'd9;
  localparam logic [3:0] OP_WFM = 4'd11;
  localparam logic [3:0] OP_BSR = 4'd12;
  localparam logic [3:0] OP_BSF = 4'd13;

  typedef struct packed {
    logic [1:0] unit;
    logic [3:0] op;
    logic       bad_form;
    logic       is_sel;
    logic       rd_data;
    logic       wr_data;
    logic       wr_class;
    logic       is_back;
  } cmd_info_t;

  // Field positions: word bit 0 is the MSB, so bits 6-7 are [9:8],
  // bits 8-11 are [7:4] and bits 12-15 are [3:0].
  function automatic cmd_info_t decode_word(input logic [9:0] w);
    cmd_info_t c;
    c.unit     = w[9:8];
    c.op       = w[3:0];
    c.bad_form = (w[7:4] != 4'd0) || (c.op >= 4'd1 && c.op <= 4'd3);
    c.is_sel   = (c.op == OP_SEL);
    c.rd_data  = (c.op == OP_RD) || (c.op == OP_RDC);
    c.wr_data  = (c.op == OP_WR) || (c.op == OP_WRZ);
    c.wr_class = (c.op >= OP_WR) && (c.op <= OP_WFM);
    c.is_back  = (c.op == OP_BSR) || (c.op == OP_BSF);
    return c;
  endfunction

  function automatic logic [1:0] next_unit(input logic [1:0] u);
    return u + 2'd1;
  endfunction

endpackage

// File: rtl/tcs_decode.sv
module tcs_decode
  import tcs_pkg::*;
(
  input  logic [9:0] word,
  output cmd_info_t  info
);
  always_comb info = decode_word(word);
endmodule

// File: rtl/tcs_poll.sv
module tcs_poll #(
  parameter int NU = 4,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [UW-1:0] cur,
  input  logic [NU-1:0] rdy,
  output logic [UW-1:0] nxt,
  output logic          rise
);
  logic [NU-1:0] seen;

  assign nxt  = cur + UW'(1);
  assign rise = rdy[nxt] & ~seen[nxt];

  for (genvar i = 0; i < NU; i++) begin : g_seen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          seen[i] <= 1'b0;
      else if (clr)                        seen[i] <= 1'b0;
      else if (step && nxt == UW'(i))      seen[i] <= rdy[i];
    end
  end
endmodule

// File: rtl/tcs_stop_timer.sv
module tcs_stop_timer #(
  parameter int STOP_CYC = 416500,
  localparam int CW = $clog2(STOP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic expire
);
  localparam logic [CW-1:0] LAST = CW'(STOP_CYC - 1);
  logic [CW-1:0] cnt;
  logic          running;

  assign expire = running && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; running <= 1'b0;
    end else if (clr) begin
      cnt <= '0; running <= 1'b0;
    end else if (start) begin
      cnt <= '0; running <= 1'b1;
    end else if (running) begin
      if (expire) running <= 1'b0;
      else        cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tape_cmd_seq.sv
module tape_cmd_seq
  import tcs_pkg::*;
#(
  parameter int STOP_CYC = 416500,
  localparam int UW = 2,
  localparam int NU = 1 << UW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr,
  input  logic          bus_clr,
  input  logic          ctl_stb,
  input  logic [15:0]   ctl_word,
  input  logic          in_xfer_tgl,
  input  logic          out_xfer_tgl,
  input  logic          sio_active,
  input  logic [NU-1:0] unit_rdy,
  input  logic [NU-1:0] unit_wring,
  input  logic [NU-1:0] unit_lp,
  input  logic          exec_done,
  input  logic          exec_err,
  input  logic          int_ack,
  input  logic          int_clr,
  output logic [UW-1:0] sel_unit,
  output logic          svc_req,
  output logic          rej_flag,
  output logic          int_req,
  output logic          int_act,
  output logic          in_xfer,
  output logic          out_xfer,
  output logic          exec_start,
  output logic [3:0]    exec_cmd,
  output logic          busy
);
  seq_state_t state;
  logic [9:0] word_q;
  logic       cmd_en, wait_rd;
  cmd_info_t  info;
  logic [UW-1:0] poll_nxt;
  logic       poll_rise, tmr_expire;
  logic       unused_hi;

  // Named internal events
  logic ev_eval, ev_reject, ev_select, ev_noop, ev_wait, ev_motion;
  logic ev_go, ev_done_ok, ev_poll, ev_raise, ev_resume;

  assign unused_hi = ^ctl_word[15:10];
  assign busy      = (state != ST_IDLE);

  tcs_decode u_dec (.word(word_q), .info(info));

  tcs_poll #(.NU(NU)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(mclr), .step(ev_poll),
    .cur(sel_unit), .rdy(unit_rdy), .nxt(poll_nxt), .rise(poll_rise)
  );

  tcs_stop_timer #(.STOP_CYC(STOP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(mclr), .start(ev_reject), .expire(tmr_expire)
  );

  always_comb begin
    ev_eval = 1'b0; ev_reject = 1'b0; ev_select = 1'b0; ev_noop = 1'b0;
    ev_wait = 1'b0; ev_motion = 1'b0; ev_go = 1'b0; ev_done_ok = 1'b0;
    ev_poll = 1'b0; ev_raise = 1'b0; ev_resume = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (in_xfer || out_xfer) ev_reject = 1'b1;
        else if (cmd_en) begin
          ev_eval = 1'b1;
          if (info.bad_form)                                ev_reject = 1'b1;
          else if (info.is_sel)                             ev_select = 1'b1;
          else if (!unit_rdy[info.unit])                    ev_reject = 1'b1;
          else if (info.wr_class && !unit_wring[info.unit]) ev_reject = 1'b1;
          else if (info.is_back && unit_lp[info.unit])      ev_noop   = 1'b1;
          else if (info.rd_data || info.wr_data)            ev_wait   = 1'b1;
          else                                              ev_motion = 1'b1;
        end else if (!sio_active) begin
          ev_poll  = 1'b1;
          ev_raise = poll_rise;
        end
      end
      ST_WAIT: begin
        if (cmd_en)                                   ev_reject = 1'b1;
        else if (wait_rd ? out_xfer : in_xfer)        ev_reject = 1'b1;
        else if (wait_rd ? in_xfer : out_xfer)        ev_go     = 1'b1;
      end
      ST_EXEC: begin
        if (exec_done) begin
          ev_raise   = exec_err;
          ev_done_ok = !exec_err;
        end
      end
      ST_REJ:  ev_raise  = tmr_expire;
      ST_HOLD: ev_resume = !int_req && !int_act;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; word_q <= '0; cmd_en <= 1'b0; wait_rd <= 1'b0;
      sel_unit <= '0; svc_req <= 1'b0; rej_flag <= 1'b0; int_req <= 1'b0;
      int_act <= 1'b0; in_xfer <= 1'b0; out_xfer <= 1'b0;
      exec_start <= 1'b0; exec_cmd <= '0;
    end else if (mclr) begin
      state <= ST_IDLE; word_q <= '0; cmd_en <= 1'b0; wait_rd <= 1'b0;
      sel_unit <= '0; svc_req <= 1'b0; rej_flag <= 1'b0; int_req <= 1'b0;
      int_act <= 1'b0; in_xfer <= 1'b0; out_xfer <= 1'b0;
      exec_start <= 1'b0; exec_cmd <= '0;
    end else begin
      exec_start <= 1'b0;
      if (ctl_stb)      svc_req  <= 1'b0;
      if (in_xfer_tgl)  in_xfer  <= 1'b1;
      if (out_xfer_tgl) out_xfer <= 1'b1;
      if (ev_eval) begin
        cmd_en <= 1'b0; rej_flag <= 1'b0; sel_unit <= info.unit;
      end
      if (ev_select || ev_noop || ev_wait || ev_done_ok) svc_req <= 1'b1;
      if (ev_wait) begin
        wait_rd <= info.rd_data; exec_cmd <= info.op; state <= ST_WAIT;
      end
      if (ev_motion) begin
        exec_start <= 1'b1; exec_cmd <= info.op; state <= ST_EXEC;
      end
      if (ev_go) begin
        exec_start <= 1'b1; state <= ST_EXEC;
      end
      if (ev_done_ok) begin
        in_xfer <= 1'b0; out_xfer <= 1'b0; state <= ST_IDLE;
      end
      if (ev_reject) begin
        rej_flag <= 1'b1; state <= ST_REJ;
      end
      if (ev_poll) sel_unit <= poll_nxt;
      if (ev_raise) begin
        int_req <= 1'b1; in_xfer <= 1'b0; out_xfer <= 1'b0;
        svc_req <= 1'b0; state <= ST_HOLD;
      end
      if (ev_resume) state <= ST_IDLE;
      if (ctl_stb) begin
        word_q <= ctl_word[9:0]; cmd_en <= 1'b1;
      end
      if (bus_clr) begin
        in_xfer <= 1'b0; out_xfer <= 1'b0; svc_req <= 1'b0;
      end
      if (int_ack && int_req) begin
        int_req <= 1'b0; int_act <= 1'b1;
      end
      if (int_clr) int_act <= 1'b0;
    end
  end

  // Assertions
  p_select_svc_r2: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (ev_select && !bus_clr) |=> svc_req);

  p_stop_wait_r8: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (state == ST_REJ && !tmr_expire) |=> (!int_req && state == ST_REJ));

  p_raise_clears_r9: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    $rose(int_req) |-> (!in_xfer && !out_xfer && !svc_req));

  p_hold_stays_r9: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (state == ST_HOLD && (int_req || int_act)) |=> (state == ST_HOLD && !exec_start));

  p_poll_step_r10: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    ev_poll |=> (sel_unit == $past(sel_unit) + 2'd1));

  p_ack_r11: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (int_ack && int_req && !int_clr) |=> (int_act && !int_req));

  p_start_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (state == ST_EXEC));

endmodule

// File: tb/tb_tape_cmd_seq.sv
module tb_tape_cmd_seq;
  localparam int STOP = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mclr, bus_clr, ctl_stb, in_xfer_tgl, out_xfer_tgl, sio_active;
  logic [15:0] ctl_word;
  logic [3:0] unit_rdy, unit_wring, unit_lp;
  logic exec_done, exec_err, int_ack, int_clr;
  logic [1:0] sel_unit;
  logic svc_req, rej_flag, int_req, int_act, in_xfer, out_xfer, exec_start, busy;
  logic [3:0] exec_cmd;

  tape_cmd_seq #(.STOP_CYC(STOP)) dut (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .bus_clr(bus_clr), .ctl_stb(ctl_stb),
    .ctl_word(ctl_word), .in_xfer_tgl(in_xfer_tgl), .out_xfer_tgl(out_xfer_tgl),
    .sio_active(sio_active), .unit_rdy(unit_rdy), .unit_wring(unit_wring),
    .unit_lp(unit_lp), .exec_done(exec_done), .exec_err(exec_err),
    .int_ack(int_ack), .int_clr(int_clr), .sel_unit(sel_unit), .svc_req(svc_req),
    .rej_flag(rej_flag), .int_req(int_req), .int_act(int_act), .in_xfer(in_xfer),
    .out_xfer(out_xfer), .exec_start(exec_start), .exec_cmd(exec_cmd), .busy(busy)
  );

  int checks = 0, failures = 0;
  string cur_req = "R12";
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 waiting for transfer,
  // 2 executing, 3 stop delay, 4 interrupt hold
  int m_st, m_sel, m_op, m_cnt;
  bit m_cmd_en, m_wait_rd, m_svc, m_rej, m_ireq, m_iact, m_inx, m_outx, m_start;
  logic [15:0] m_word;
  bit m_seen [4];

  task automatic m_reset();
    m_st = 0; m_sel = 0; m_op = 0; m_cnt = 0; m_cmd_en = 0; m_wait_rd = 0;
    m_svc = 0; m_rej = 0; m_ireq = 0; m_iact = 0; m_inx = 0; m_outx = 0;
    m_start = 0; m_word = '0;
    for (int i = 0; i < 4; i++) m_seen[i] = 0;
  endtask

  task automatic m_reject();
    m_rej = 1; m_st = 3; m_cnt = 0;
  endtask

  task automatic m_raise();
    m_ireq = 1; m_inx = 0; m_outx = 0; m_svc = 0; m_st = 4;
  endtask

  always @(posedge clk) begin
    if (!rst_n || mclr) m_reset();
    else begin
      int o_st, u, op;
      bit o_inx, o_outx, o_cen, o_ireq, o_iact, bad, rdc, wrc, wcl, bk;
      o_st = m_st; o_inx = m_inx; o_outx = m_outx; o_cen = m_cmd_en;
      o_ireq = m_ireq; o_iact = m_iact;
      u = int'(m_word[9:8]); op = int'(m_word[3:0]);
      bad = (m_word[7:4] != 0) || (op >= 1 && op <= 3);
      rdc = (op == 4 || op == 5); wrc = (op == 8 || op == 9);
      wcl = (op >= 8 && op <= 11); bk = (op == 12 || op == 13);
      m_start = 0;
      if (ctl_stb) m_svc = 0;
      if (in_xfer_tgl) m_inx = 1;
      if (out_xfer_tgl) m_outx = 1;
      case (o_st)
        0: if (o_inx || o_outx) m_reject();
           else if (o_cen) begin
             m_cmd_en = 0; m_rej = 0; m_sel = u;
             if (bad) m_reject();
             else if (op == 0) m_svc = 1;
             else if (!unit_rdy[u]) m_reject();
             else if (wcl && !unit_wring[u]) m_reject();
             else if (bk && unit_lp[u]) m_svc = 1;
             else if (rdc || wrc) begin m_svc = 1; m_wait_rd = rdc; m_op = op; m_st = 1; end
             else begin m_start = 1; m_op = op; m_st = 2; end
           end else if (!sio_active) begin
             m_sel = (m_sel + 1) % 4;
             if (unit_rdy[m_sel] && !m_seen[m_sel]) m_raise();
             m_seen[m_sel] = unit_rdy[m_sel];
           end
        1: if (o_cen) m_reject();
           else if (m_wait_rd ? o_outx : o_inx) m_reject();
           else if (m_wait_rd ? o_inx : o_outx) begin m_start = 1; m_st = 2; end
        2: if (exec_done) begin
             if (exec_err) m_raise();
             else begin m_svc = 1; m_inx = 0; m_outx = 0; m_st = 0; end
           end
        3: if (m_cnt == STOP - 1) m_raise(); else m_cnt++;
        4: if (!o_ireq && !o_iact) m_st = 0;
        default: ;
      endcase
      if (ctl_stb) begin m_word = ctl_word; m_cmd_en = 1; end
      if (bus_clr) begin m_inx = 0; m_outx = 0; m_svc = 0; end
      if (int_ack && o_ireq) begin m_ireq = 0; m_iact = 1; end
      if (int_clr) m_iact = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "sel_unit", int'(sel_unit), m_sel);
      chk(cur_req, "svc_req", int'(svc_req), int'(m_svc));
      chk(cur_req, "rej_flag", int'(rej_flag), int'(m_rej));
      chk(cur_req, "int_req", int'(int_req), int'(m_ireq));
      chk(cur_req, "int_act", int'(int_act), int'(m_iact));
      chk(cur_req, "in_xfer", int'(in_xfer), int'(m_inx));
      chk(cur_req, "out_xfer", int'(out_xfer), int'(m_outx));
      chk(cur_req, "exec_start", int'(exec_start), int'(m_start));
      chk(cur_req, "exec_cmd", int'(exec_cmd), m_op);
      chk(cur_req, "busy", int'(busy), int'(m_st != 0));
    end
  end

  function automatic logic [15:0] mkw(int u, int op, int resv);
    return {6'b0, 2'(u), 4'(resv), 4'(op)};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic [15:0] w);
    ctl_word = w; ctl_stb = 1; @(negedge clk); ctl_stb = 0;
  endtask

  task automatic serve();
    int n = 0;
    while (!int_req && n < 64) begin @(negedge clk); n++; end
    if (int_req) begin
      int_ack = 1; @(negedge clk); int_ack = 0; @(negedge clk);
      int_clr = 1; @(negedge clk); int_clr = 0; @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; mclr = 0; bus_clr = 0; ctl_stb = 0; ctl_word = '0;
    in_xfer_tgl = 0; out_xfer_tgl = 0; sio_active = 1;
    unit_rdy = 4'b0111; unit_wring = 4'b1011; unit_lp = 4'b0010;
    exec_done = 0; exec_err = 0; int_ack = 0; int_clr = 0;
    cyc(3); rst_n = 1; cyc(2);
    // R12 reset state
    chk("R12", "reset sel_unit", int'(sel_unit), 0);
    chk("R12", "reset int_req", int'(int_req), 0);
    chk("R12", "reset busy", int'(busy), 0);

    cur_req = "R2";  strobe(mkw(3, 0, 0)); cyc(3);
    chk("R2", "select svc_req", int'(svc_req), 1);
    cur_req = "R1";  strobe(mkw(0, 4, 1)); serve();
    strobe(mkw(1, 2, 0)); serve();
    cur_req = "R3";  strobe(mkw(3, 4, 0)); serve();
    strobe(mkw(2, 8, 0)); serve();
    cur_req = "R4";  strobe(mkw(0, 4, 0)); cyc(3);
    in_xfer_tgl = 1; cyc(1); in_xfer_tgl = 0; cyc(2);
    exec_done = 1; cyc(1); exec_done = 0; cyc(2);
    strobe(mkw(0, 8, 0)); cyc(2);
    in_xfer_tgl = 1; cyc(1); in_xfer_tgl = 0; serve();
    strobe(mkw(1, 5, 0)); cyc(2); strobe(mkw(0, 0, 0)); serve(); cyc(3);
    cur_req = "R5";  out_xfer_tgl = 1; cyc(1); out_xfer_tgl = 0; serve();
    cur_req = "R6";  strobe(mkw(1, 12, 0)); cyc(3);
    chk("R6", "backspace at LP no motion busy", int'(busy), 0);
    strobe(mkw(0, 13, 0)); cyc(2); exec_done = 1; cyc(1); exec_done = 0; cyc(2);
    cur_req = "R7";  strobe(mkw(0, 14, 0)); cyc(3);
    exec_done = 1; exec_err = 1; cyc(1); exec_done = 0; exec_err = 0; serve();
    cur_req = "R8";  strobe(mkw(0, 3, 0)); cyc(STOP + 4); serve();
    cur_req = "R9";  strobe(mkw(2, 11, 0)); cyc(STOP + 3);
    strobe(mkw(2, 0, 0)); cyc(3); serve(); cyc(4);
    cur_req = "R11"; strobe(mkw(0, 1, 0)); cyc(STOP + 4);
    int_ack = 1; cyc(1); int_ack = 0; cyc(4); int_clr = 1; cyc(1); int_clr = 0; cyc(3);
    cur_req = "R12"; strobe(mkw(1, 7, 8)); cyc(STOP + 4);
    in_xfer_tgl = 1; out_xfer_tgl = 1; cyc(1); in_xfer_tgl = 0; out_xfer_tgl = 0; cyc(2);
    bus_clr = 1; cyc(1); bus_clr = 0; cyc(2); serve();
    strobe(mkw(0, 4, 0)); cyc(2); mclr = 1; cyc(1); mclr = 0; cyc(3);
    cur_req = "R10"; sio_active = 0;
    for (int k = 0; k < 5; k++) serve();
    unit_rdy = 4'b1111;
    for (int k = 0; k < 3; k++) serve();
    sio_active = 1; cyc(4);
    finish_run();
  end
endmodule